// File: doc/BRIEF.md
# Buffered Host Transfer Engine

This block moves bytes from a sector buffer to a downstream consumer at a fixed pace of one byte per programmable step period. Software loads a 16-bit start address and a 16-bit byte count (each as a low and a high byte), sets the output-enable bit in the interface control register and writes the trigger register. The engine then reads the buffer at the current address, offers the byte on a valid/accept output, and on each accepted byte advances the address and counts down.

The count runs down past zero: a loaded count of N delivers N+1 bytes, and the transfer ends when both count bytes wrap to 0xFF. If the consumer refuses a byte, the engine parks with its address and count untouched. A pulse on the resume input restarts it with whatever is left. The buffer itself is outside the block. The engine drives a read address (the data address reduced to the buffer's index width) and takes the byte back combinationally. Status flags are active low, and an interrupt request is raised when a flag is low and its enable bit is set.

Top module: `host_xfer_engine`

## Requirements
- R1: After reset the status byte reads 0xFF (both flags inactive), `irq` is 0, `out_valid` is 0 and the address and count read 0.
- R2: A write to the trigger register (select 5) sets the busy flag low (status bit 1) and starts pacing only when output-enable (control bit 7) is set. Without output-enable the write has no effect.
- R3: While running, the engine offers exactly one byte every STEP clock cycles. `out_data` is the buffer byte at `buf_addr`, which equals the data address modulo 2^ADDR_W.
- R4: Each accepted byte increments the 16-bit data address and decrements the low count byte. When the low byte wraps from 0x00 to 0xFF, the high count byte is decremented.
- R5: A loaded count of N yields N+1 offered bytes. At the byte that wraps both count bytes, the done flag (status bit 0) goes low, busy returns high, pacing stops and the count reads 0xFFFF.
- R6: A byte offered while `out_ready` is low is refused. The engine pauses with address and count unchanged, busy stays low and no further byte is offered.
- R7: `resume` restarts a paused transfer only when output-enable is set, busy is low, the engine is not running and the remaining count is nonzero. In every other case it is ignored.
- R8: Writing the control register (select 0) with output-enable clear sets busy high and cancels any running or paused transfer.
- R9: `irq` is 1 exactly when the done flag is low and the done interrupt enable (control bit 0) is set.
- R10: Register selects are 1 count low, 2 count high, 3 address low and 4 address high. A register write to these selects takes priority over the engine's own update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 control, 1/2 count lo/hi, 3/4 address lo/hi, 5 trigger) |
| reg_wdata | input | 8 | Register write data |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_rdata | input | 8 | Buffer read data for `buf_addr` |
| out_valid | output | 1 | A byte is offered this cycle |
| out_data | output | 8 | Offered byte |
| out_ready | input | 1 | Consumer accepts the offered byte |
| resume | input | 1 | Restart request after a refusal |
| status | output | 8 | Status flags, active low: bit 0 done, bit 1 busy, others 1 |
| irq | output | 1 | Interrupt request |
| xfer_addr | output | 16 | Current data address |
| xfer_count | output | 16 | Remaining count |

## Verification
The bench builds the engine with STEP set to 4 and ADDR_W left at 14. The short step keeps a transfer of 257 bytes, which is needed to cross the high count byte, to roughly a thousand cycles. The spacing between offered bytes is still measured against the parameter. Keeping the full 14-bit index allows a start address near the top of the buffer, so the check can show the read address folding to zero while the 16-bit data address keeps counting.

// File: rtl/hte_pkg.sv
// Package: shared register selects and bit positions for the transfer engine.
// Assumes: an 8-bit register write port with a 3-bit select.
package hte_pkg;
    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_ADR_LO = 3'd3,
        SEL_ADR_HI = 3'd4,
        SEL_TRIG   = 3'd5
    } hte_sel_e;

    localparam int CTRL_OE_BIT   = 7;
    localparam int CTRL_DONE_IE  = 0;
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_BUSY_BIT = 1;
    localparam logic [7:0] IRQ_SRC_MASK = 8'h01;
endpackage

// File: rtl/hte_pacer.sv
// Module: step pacer. Produces one tick every STEP cycles while enabled.
// Assumes: restart has priority and puts the phase back to zero.
module hte_pacer #(
    parameter int STEP = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [PW-1:0] LAST = PW'(STEP - 1);

    logic [PW-1:0] phase;

    assign tick = run && (phase == LAST);

    // Advance the phase counter while running, wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || !run || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R3: the phase never exceeds the last step index.
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
endmodule

// File: rtl/hte_counter.sv
// Module: data address and byte count registers with borrow from low to high.
// Assumes: software writes win over an accepted byte in the same cycle.
module hte_counter
    import hte_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        accept,
    output logic [15:0] addr,
    output logic [15:0] count,
    output logic        count_zero
);
    logic [7:0] cnt_lo, cnt_hi, adr_lo, adr_hi;

    assign addr       = {adr_hi, adr_lo};
    assign count      = {cnt_hi, cnt_lo};
    assign count_zero = (count == 16'h0000);

    // Load from the register port or step on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            adr_lo <= '0;
            adr_hi <= '0;
        end else if (reg_we && (reg_sel inside {SEL_CNT_LO, SEL_CNT_HI, SEL_ADR_LO, SEL_ADR_HI})) begin
            case (reg_sel)
                SEL_CNT_LO: cnt_lo <= reg_wdata;
                SEL_CNT_HI: cnt_hi <= reg_wdata;
                SEL_ADR_LO: adr_lo <= reg_wdata;
                default:    adr_hi <= reg_wdata;
            endcase
        end else if (accept) begin
            {adr_hi, adr_lo} <= {adr_hi, adr_lo} + 16'd1;
            cnt_lo <= cnt_lo - 8'd1;
            if (cnt_lo == 8'h00) begin
                cnt_hi <= cnt_hi - 8'd1;
            end
        end
    end

    // R4: an accepted byte with no register write advances address and count.
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !reg_we) |=> (addr == $past(addr) + 16'd1) && (count == $past(count) - 16'd1));

    // R6/R10: with neither accept nor write, address and count hold.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !reg_we) |=> $stable(addr) && $stable(count));
endmodule

// File: rtl/hte_ctrl.sv
// Module: control register, run/pause state and active-low status flags.
// Assumes: a start or resume restarts the pacer phase; OE clear overrides all.
module hte_ctrl
    import hte_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       resume,
    input  logic       offer,
    input  logic       out_ready,
    input  logic       count_zero,
    output logic       running,
    output logic       restart,
    output logic [7:0] status,
    output logic       irq
);
    logic [7:0] ctrl_q;
    logic       busy_n, done_n;
    logic       oe, wr_ctrl, oe_off, start, go_on, accept, refuse, finish;

    assign oe      = ctrl_q[CTRL_OE_BIT];
    assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
    assign oe_off  = wr_ctrl && !reg_wdata[CTRL_OE_BIT];
    assign start   = reg_we && (reg_sel == SEL_TRIG) && oe;
    assign go_on   = resume && oe && !busy_n && !running && !count_zero;
    assign accept  = offer && out_ready;
    assign refuse  = offer && !out_ready;
    assign finish  = accept && count_zero;
    assign restart = start || go_on;

    assign status = {6'h3F, busy_n, done_n};
    assign irq    = |(~status & ctrl_q & IRQ_SRC_MASK);

    // Hold the interface control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata;
        end
    end

    // Run/pause state and the two active-low flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            busy_n  <= 1'b1;
            done_n  <= 1'b1;
        end else if (oe_off) begin
            running <= 1'b0;
            busy_n  <= 1'b1;
        end else if (start) begin
            running <= 1'b1;
            busy_n  <= 1'b0;
        end else if (go_on) begin
            running <= 1'b1;
        end else if (finish) begin
            running <= 1'b0;
            busy_n  <= 1'b1;
            done_n  <= 1'b0;
        end else if (refuse) begin
            running <= 1'b0;
        end
    end

    // R2: a trigger with output-enable set drives busy low.
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wr_ctrl) |=> !status[STAT_BUSY_BIT]);

    // R8: clearing output-enable returns busy high and stops running.
    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        oe_off |=> status[STAT_BUSY_BIT] && !running);

    // R5: the done flag falls only together with busy returning high.
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[STAT_DONE_BIT]) |-> status[STAT_BUSY_BIT] && !running);

    // R6: a refused byte stops the engine while busy stays low.
    a_r6_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (refuse && !reg_we) |=> !running && !status[STAT_BUSY_BIT]);

    // R3: the engine runs only while busy is low.
    a_r3_run_busy: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !status[STAT_BUSY_BIT]);

    // R9: irq follows the done flag and its enable.
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (!status[STAT_DONE_BIT] && ctrl_q[CTRL_DONE_IE]));
endmodule

// File: rtl/host_xfer_engine.sv
// Module: top of the buffered host transfer engine.
// Assumes: the sector buffer is external with a combinational read port.
module host_xfer_engine #(
    parameter int STEP   = 24,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    input  logic              resume,
    output logic [7:0]        status,
    output logic              irq,
    output logic [15:0]       xfer_addr,
    output logic [15:0]       xfer_count
);
    logic running, restart, tick, count_zero, accept;

    assign out_valid = tick;
    assign out_data  = buf_rdata;
    assign buf_addr  = xfer_addr[ADDR_W-1:0];
    assign accept    = out_valid && out_ready;

    hte_pacer #(.STEP(STEP)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (restart),
        .tick    (tick)
    );

    hte_counter u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .accept     (accept),
        .addr       (xfer_addr),
        .count      (xfer_count),
        .count_zero (count_zero)
    );

    hte_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .resume     (resume),
        .offer      (out_valid),
        .out_ready  (out_ready),
        .count_zero (count_zero),
        .running    (running),
        .restart    (restart),
        .status     (status),
        .irq        (irq)
    );

    // R3: a byte is offered only while busy is low.
    a_r3_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !status[1]);

    // R5: once the done flag falls, the count reads all ones.
    a_r5_end_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> xfer_count == 16'hFFFF);
endmodule

// File: tb/tb_host_xfer_engine.sv
module tb_host_xfer_engine;
    localparam int STEP   = 4;
    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_sel = '0;
    logic [7:0]        reg_wdata = '0;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_rdata;
    logic              out_valid;
    logic [7:0]        out_data;
    logic              out_ready = 1'b1;
    logic              resume = 1'b0;
    logic [7:0]        status;
    logic              irq;
    logic [15:0]       xfer_addr, xfer_count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] pattern(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
    endfunction

    assign buf_rdata = pattern(buf_addr);

    host_xfer_engine #(.STEP(STEP), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .resume(resume), .status(status), .irq(irq),
        .xfer_addr(xfer_addr), .xfer_count(xfer_count)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("watchdog expired");
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; reg_we = 1'b0; resume = 1'b0; out_ready = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] n, input logic [7:0] ctl);
        wr(3'd0, ctl);
        wr(3'd3, a[7:0]); wr(3'd4, a[15:8]);
        wr(3'd1, n[7:0]); wr(3'd2, n[15:8]);
    endtask

    task automatic pulse_resume();
        @(posedge clk); #1; resume = 1'b1;
        @(posedge clk); #1; resume = 1'b0;
    endtask

    // Wait at negedges for an offered byte; returns the cycle it appeared.
    task automatic wait_valid(input int limit, output bit seen, output int at);
        seen = 0; at = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (out_valid) begin seen = 1; at = cyc; break; end
        end
    endtask

    // Count offered bytes over a window (no byte expected).
    task automatic quiet(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid) hits++;
        end
    endtask

    // Receive n bytes from address a, checking data and spacing.
    task automatic receive(input string req, input logic [15:0] a, input int n);
        bit seen; int at; int prev;
        prev = -1;
        for (int k = 0; k < n; k++) begin
            wait_valid(4 * STEP, seen, at);
            chk({req, " byte offered"}, 32'(seen), 32'd1);
            if (!seen) return;
            chk({req, " data"}, 32'(out_data), 32'(pattern(ADDR_W'(a + 16'(k)))));
            if (prev >= 0) chk("R3 spacing", 32'(at - prev), 32'(STEP));
            prev = at;
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 status", 32'(status), 32'hFF);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 addr", 32'(xfer_addr), 0);
        chk("R1 count", 32'(xfer_count), 0);
    endtask

    task automatic t_no_oe();
        int h;
        do_reset();
        load(16'h0020, 16'd2, 8'h01);
        wr(3'd5, 8'h00);
        quiet(5 * STEP, h);
        chk("R2 no start without OE busy", 32'(status[1]), 1);
        chk("R2 no start without OE bytes", 32'(h), 0);
    endtask

    task automatic t_basic();
        int h;
        do_reset();
        load(16'h0010, 16'd3, 8'h81);
        wr(3'd5, 8'h00);
        @(negedge clk);
        chk("R2 busy low after trigger", 32'(status[1]), 0);
        receive("R3", 16'h0010, 4);
        quiet(3 * STEP, h);
        chk("R5 exactly N+1 bytes", 32'(h), 0);
        chk("R5 done low", 32'(status[0]), 0);
        chk("R5 busy high", 32'(status[1]), 1);
        chk("R5 count FFFF", 32'(xfer_count), 32'hFFFF);
        chk("R4 address advanced", 32'(xfer_addr), 32'h0014);
        chk("R9 irq with enable", 32'(irq), 1);
    endtask

    task automatic t_hi_wrap();
        bit seen; int at;
        do_reset();
        load(16'h0100, 16'h0100, 8'h80);
        wr(3'd5, 8'h00);
        receive("R4", 16'h0100, 1);
        @(negedge clk);
        chk("R4 low wraps, high borrows", 32'(xfer_count), 32'h00FF);
        receive("R4", 16'h0101, 256);
        wait_valid(3 * STEP, seen, at);
        chk("R5 257 bytes then stop", 32'(seen), 0);
        chk("R5 count FFFF after hi wrap", 32'(xfer_count), 32'hFFFF);
        chk("R4 address 0x0201", 32'(xfer_addr), 32'h0201);
        chk("R9 irq masked", 32'(irq), 0);
        chk("R5 done low, irq disabled", 32'(status[0]), 0);
    endtask

    task automatic t_pause();
        bit seen; int at; int h;
        do_reset();
        load(16'h0200, 16'd5, 8'h80);
        wr(3'd5, 8'h00);
        receive("R6", 16'h0200, 2);
        wait_valid(4 * STEP, seen, at);
        out_ready = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        quiet(4 * STEP, h);
        chk("R6 no bytes while paused", 32'(h), 0);
        chk("R6 address kept", 32'(xfer_addr), 32'h0202);
        chk("R6 count kept", 32'(xfer_count), 32'd3);
        chk("R6 busy stays low", 32'(status[1]), 0);
        pulse_resume();
        receive("R7 resumed", 16'h0202, 4);
        quiet(3 * STEP, h);
        chk("R7 ends after remainder", 32'(h), 0);
        chk("R7 done low", 32'(status[0]), 0);
    endtask

    task automatic t_resume_zero();
        bit seen; int at; int h;
        do_reset();
        load(16'h0300, 16'd0, 8'h80);
        wr(3'd5, 8'h00);
        wait_valid(4 * STEP, seen, at);
        out_ready = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        pulse_resume();
        quiet(4 * STEP, h);
        chk("R7 resume ignored at zero count", 32'(h), 0);
        chk("R7 count still zero", 32'(xfer_count), 0);
        // R8: cancel with OE clear, then resume with count nonzero is ignored
        wr(3'd1, 8'h04);
        wr(3'd0, 8'h00);
        @(negedge clk);
        chk("R8 busy high after OE clear", 32'(status[1]), 1);
        pulse_resume();
        quiet(4 * STEP, h);
        chk("R7 resume ignored without OE", 32'(h), 0);
    endtask

    task automatic t_cancel();
        int h;
        do_reset();
        load(16'h0400, 16'd50, 8'h81);
        wr(3'd5, 8'h00);
        receive("R8 pre-cancel", 16'h0400, 3);
        wr(3'd0, 8'h01);
        @(negedge clk);
        chk("R8 busy high", 32'(status[1]), 1);
        quiet(5 * STEP, h);
        chk("R8 no bytes after cancel", 32'(h), 0);
        chk("R8 done not set", 32'(status[0]), 1);
        wr(3'd0, 8'h81);
        pulse_resume();
        quiet(4 * STEP, h);
        chk("R7 resume ignored when idle", 32'(h), 0);
    endtask

    task automatic t_addr_wrap();
        do_reset();
        load(16'h3FFF, 16'd1, 8'h80);
        wr(3'd5, 8'h00);
        receive("R3", 16'h3FFF, 1);
        @(negedge clk);
        chk("R3 buffer index folds", 32'(buf_addr), 0);
        receive("R3", 16'h4000, 1);
        @(negedge clk);
        chk("R4 address passes 14 bits", 32'(xfer_addr), 32'h4001);
    endtask

    task automatic t_write_priority();
        bit seen; int at;
        do_reset();
        load(16'h0500, 16'd8, 8'h80);
        wr(3'd5, 8'h00);
        wait_valid(4 * STEP, seen, at);
        // write the address low register in the accepting cycle
        #1; reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 8'h40;
        @(posedge clk); #1; reg_we = 1'b0;
        @(negedge clk);
        chk("R10 write wins over step", 32'(xfer_addr), 32'h0540);
        chk("R10 count unchanged on write", 32'(xfer_count), 32'd8);
    endtask

    initial begin
        t_reset();
        t_no_oe();
        t_basic();
        t_hi_wrap();
        t_pause();
        t_resume_zero();
        t_cancel();
        t_addr_wrap();
        t_write_priority();
        finish_run();
    end
endmodule